// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block turns a 32,768 Hz oscillator enable into a one-second tick. It trims the rate digitally instead of with tuning capacitors: in chosen seconds it either removes or adds whole periods of the divide-by-128 stage. Each enable is one clock cycle of the block's clock on which `oscEn` is high. The prescaler is split into a low stage (divide by 128) and a high stage (256 low-stage carries per second), and the correction works only on the carries of the low stage.

A 5-bit magnitude and a sign select the correction. A 64-minute schedule decides which minutes get one trimmed second. With magnitude N, the first second of each of the first 2N minutes of the schedule is trimmed. A positive sign shortens that second, which speeds the clock up. A negative sign lengthens it, which slows the clock down. The block also gives a square wave taken from the uncorrected low stage, which can be used to measure the oscillator, and the current position in the 64-minute schedule. A stop input freezes all counters without clearing them.

Top module: `sec_trim_prescaler`

## Requirements
- R1: After reset, `secTick` and `testWave` are 0, `minutePhase` is 0, the latched calibration is magnitude 0, and the second counter within the minute is 0.
- R2: An unmodified second lasts 32,768 enables. `secTick` is high for exactly one clock cycle: the cycle after the clock edge that samples the enable which ends the second.
- R3: With the sign bit at 1 (positive), a modified second is 256 enables shorter (32,512), because two low-stage carries are skipped.
- R4: With the sign bit at 0 (negative), a modified second is 128 enables longer (32,896), because one low-stage carry is blanked.
- R5: A second is modified only when it is second 0 of a minute and `minutePhase` < 2×N, where N is the latched magnitude. So a magnitude of 0 modifies nothing, and phases 62 and 63 are never modified.
- R6: `minutePhase` counts minutes of 60 seconds modulo 64. It changes only together with the `secTick` that ends the last second of a minute, and it steps by exactly 1.
- R7: `calMag` and `calSign` are sampled only on the edge that ends a minute. A change at any other time has no effect until the next minute starts, and a change never restarts the 64-minute phase.
- R8: `testWave` is a square wave with a period of 64 enables (512 Hz). It is high while the count of enables since reset, modulo 64, is 32 to 63. It does not depend on the calibration.
- R9: While `stop` is high, `oscEn` is ignored. No counter moves, `secTick` stays 0, and counting resumes from the frozen state when `stop` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous reset, active low |
| oscEn | input | 1 | One-cycle enable per oscillator period |
| stop | input | 1 | Freezes all counters while high |
| calMag | input | CAL_BITS | Calibration magnitude N (0 to 31) |
| calSign | input | 1 | 1 = positive (shorter second), 0 = negative (longer second) |
| secTick | output | 1 | One-cycle pulse at the end of each second |
| testWave | output | 1 | Uncorrected 512 Hz square wave |
| minutePhase | output | CAL_BITS+1 | Minute index within the 64-minute schedule |

## Verification
The bench runs the prescaler with reduced stage widths and a 2-second minute, so that several full 64-minute schedules fit in the run. A behavioural model, which only counts enables and second lengths, is compared with all three outputs on every cycle. The enable is driven in three patterns: on every cycle, on every third cycle, and from a pseudo-random sequence with bursts of `stop`. The first two patterns show whether second lengths are counted in enables and not in clock cycles. The third pattern tests freezing and resuming. The calibration is tried at full positive and full negative magnitude, at zero, and while changing in the middle of a minute. These runs separate shortening from lengthening, show the phase-62/63 exclusion, and show whether the calibration is sampled only at the minute boundary.

// File: rtl/sec_trim_pkg.sv
package sec_trim_pkg;

  // Number of low-stage carries skipped in a positively trimmed second.
  localparam int POS_SKIP_CARRIES = 2;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic oscStep;   // the low stage counts this cycle
    logic jumpHi;    // skip carries: load the high stage past zero
    logic holdHi;    // blank one carry: the high stage does not advance
  } dpStrobes_t;

endpackage

// File: rtl/sec_trim_datapath.sv
module sec_trim_datapath
  import sec_trim_pkg::*;
#(
  parameter int LO_BITS = 7,
  parameter int HI_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobes_t strobes,
  output logic       loWrap,
  output logic       hiZero,
  output logic       hiFull,
  output logic       secTick,
  output logic       testWave
);

  localparam int WAVE_BIT = LO_BITS - 2;
  localparam logic [HI_BITS-1:0] HI_JUMP = HI_BITS'(POS_SKIP_CARRIES + 1);

  logic [LO_BITS-1:0] loCnt;
  logic [HI_BITS-1:0] hiCnt;
  logic               carry;

  assign loWrap   = (loCnt == '1);
  assign hiZero   = (hiCnt == '0);
  assign hiFull   = (hiCnt == '1);
  assign carry    = strobes.oscStep && loWrap;
  assign testWave = loCnt[WAVE_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loCnt   <= '0;
      hiCnt   <= '0;
      secTick <= 1'b0;
    end else begin
      secTick <= carry && hiFull;
      if (strobes.oscStep) loCnt <= loCnt + 1'b1;
      if (carry) begin
        if (strobes.jumpHi)      hiCnt <= HI_JUMP;
        else if (!strobes.holdHi) hiCnt <= hiCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sec_trim_ctrl.sv
module sec_trim_ctrl
  import sec_trim_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int CAL_BITS    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                oscEn,
  input  logic                stop,
  input  logic [CAL_BITS-1:0] calMag,
  input  logic                calSign,
  input  logic                loWrap,
  input  logic                hiZero,
  input  logic                hiFull,
  output dpStrobes_t          strobes,
  output logic [CAL_BITS:0]   minutePhase
);

  localparam int PHASE_BITS = CAL_BITS + 1;
  localparam int SEC_W      = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

  logic [SEC_W-1:0]      secCnt;
  logic [PHASE_BITS-1:0] phase;
  logic [CAL_BITS-1:0]   magL;
  logic                  signL;
  logic                  blanked;
  logic                  step, carryNow, modSec, secEnd, minEnd;

  assign step     = oscEn && !stop;
  assign carryNow = step && loWrap;
  // first second of a minute that lies inside the first 2N minutes
  assign modSec   = (secCnt == '0) && (phase < {magL, 1'b0});
  assign secEnd   = carryNow && hiFull;
  assign minEnd   = secEnd && (secCnt == SEC_LAST);

  always_comb begin
    strobes.oscStep = step;
    strobes.jumpHi  = carryNow && modSec && signL && hiZero;
    strobes.holdHi  = carryNow && modSec && !signL && hiZero && !blanked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCnt  <= '0;
      phase   <= '0;
      magL    <= '0;
      signL   <= 1'b0;
      blanked <= 1'b0;
    end else begin
      if (secEnd)              blanked <= 1'b0;
      else if (strobes.holdHi) blanked <= 1'b1;
      if (secEnd) secCnt <= minEnd ? '0 : secCnt + 1'b1;
      if (minEnd) begin
        phase <= phase + 1'b1;
        magL  <= calMag;
        signL <= calSign;
      end
    end
  end

  assign minutePhase = phase;

endmodule

// File: rtl/sec_trim_prescaler.sv
module sec_trim_prescaler
  import sec_trim_pkg::*;
#(
  parameter int LO_BITS     = 7,
  parameter int HI_BITS     = 8,
  parameter int SEC_PER_MIN = 60,
  parameter int CAL_BITS    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                oscEn,
  input  logic                stop,
  input  logic [CAL_BITS-1:0] calMag,
  input  logic                calSign,
  output logic                secTick,
  output logic                testWave,
  output logic [CAL_BITS:0]   minutePhase
);

  dpStrobes_t strobes;
  logic       loWrap, hiZero, hiFull;

  sec_trim_ctrl #(
    .SEC_PER_MIN(SEC_PER_MIN),
    .CAL_BITS   (CAL_BITS)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .oscEn      (oscEn),
    .stop       (stop),
    .calMag     (calMag),
    .calSign    (calSign),
    .loWrap     (loWrap),
    .hiZero     (hiZero),
    .hiFull     (hiFull),
    .strobes    (strobes),
    .minutePhase(minutePhase)
  );

  sec_trim_datapath #(
    .LO_BITS(LO_BITS),
    .HI_BITS(HI_BITS)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .loWrap  (loWrap),
    .hiZero  (hiZero),
    .hiFull  (hiFull),
    .secTick (secTick),
    .testWave(testWave)
  );

endmodule

// File: rtl/sec_trim_chk.sv
module sec_trim_chk #(
  parameter int PHASE_BITS = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  oscEn,
  input logic                  stop,
  input logic                  secTick,
  input logic                  testWave,
  input logic [PHASE_BITS-1:0] minutePhase
);

  // R2
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick);

  // R2
  tick_on_osc_chk: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> $past(oscEn && !stop));

  // R9
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> ($stable(minutePhase) && $stable(testWave) && !secTick));

  // R6
  phase_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (minutePhase != $past(minutePhase)) |->
      (minutePhase == PHASE_BITS'($past(minutePhase) + 1'b1)));

  // R6
  phase_with_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (minutePhase != $past(minutePhase)) |-> secTick);

  // R8
  wave_on_osc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testWave != $past(testWave)) |-> $past(oscEn && !stop));

endmodule

bind sec_trim_prescaler sec_trim_chk #(.PHASE_BITS(CAL_BITS + 1)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .oscEn      (oscEn),
  .stop       (stop),
  .secTick    (secTick),
  .testWave   (testWave),
  .minutePhase(minutePhase)
);

// File: tb/sec_trim_prescaler_tb_top.sv
module sec_trim_prescaler_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LO   = 3;
  localparam int HI   = 2;
  localparam int SPM  = 2;
  localparam int CALB = 5;
  localparam int BASE_LEN  = 1 << (LO + HI);
  localparam int CARRY_LEN = 1 << LO;
  localparam int HALF_WAVE = 1 << (LO - 2);
  localparam int WATCHDOG  = 200000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            oscEn = 1'b0;
  logic            stop = 1'b0;
  logic [CALB-1:0] calMag = '0;
  logic            calSign = 1'b0;
  logic            secTick, testWave;
  logic [CALB:0]   minutePhase;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // reference model state
  int mTotal = 0, mCnt = 0, mSec = 0, mPhase = 0, mMag = 0, mSign = 0;
  int expTick = 0;
  bit mModCur = 0;

  sec_trim_prescaler #(
    .LO_BITS(LO), .HI_BITS(HI), .SEC_PER_MIN(SPM), .CAL_BITS(CALB)
  ) dut_i (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .stop(stop),
    .calMag(calMag), .calSign(calSign),
    .secTick(secTick), .testWave(testWave), .minutePhase(minutePhase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic bit isMod();
    return (mSec == 0) && (mPhase < 2 * mMag);
  endfunction

  function automatic int secLen();
    if (!isMod()) return BASE_LEN;
    return mSign ? BASE_LEN - 2 * CARRY_LEN : BASE_LEN + CARRY_LEN;
  endfunction

  // behavioural model, updated on every edge
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mTotal = 0; mCnt = 0; mSec = 0; mPhase = 0; mMag = 0; mSign = 0; expTick = 0;
    end else begin
      expTick = 0;
      if (oscEn && !stop) begin
        mModCur = isMod();
        mTotal++;
        mCnt++;
        if (mCnt == secLen()) begin
          expTick = 1;
          mCnt = 0;
          mSec++;
          if (mSec == SPM) begin
            mSec = 0;
            mPhase = (mPhase + 1) % 64;
            mMag = int'(calMag);
            mSign = int'(calSign);
          end
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      string t;
      if (stop)                                                    t = "R9";
      else if (mModCur && mSign == 1)                              t = "R3";
      else if (mModCur && mSign == 0)                              t = "R4";
      else if (int'(calMag) != mMag || int'(calSign) != mSign)     t = "R7";
      else if (mSec == 0)                                          t = "R5";
      else                                                         t = "R2";
      check({t, " secTick"}, int'(secTick), expTick);
      check("R6 minutePhase", int'(minutePhase), mPhase);
      check("R8 testWave", int'(testWave), int'((mTotal % (2 * HALF_WAVE)) >= HALF_WAVE));
    end
  end

  always @(posedge clk) begin
    if (cycles >= WATCHDOG && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // mode 0: every cycle, 1: every third cycle, 2: pseudo-random with stop bursts
  task automatic run(int mode, int n, bit wiggleCal);
    logic [7:0] lfsr = 8'h5A;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (mode)
        0: oscEn = 1'b1;
        1: oscEn = (i % 3 == 0);
        default: oscEn = lfsr[0] | lfsr[2];
      endcase
      stop = (mode == 2) && ((i % 211) < 37);
      if (wiggleCal && (i % 37 == 0)) begin
        calMag  = CALB'(i % 29);
        calSign = lfsr[1];
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 secTick", int'(secTick), 0);
    check("R1 minutePhase", int'(minutePhase), 0);
    check("R1 testWave", int'(testWave), 0);
    rstN = 1'b1;
    // full positive trim, enable every cycle: R3 and phases 62/63 untouched (R5)
    calMag = 5'd31; calSign = 1'b1;
    run(0, 4000, 1'b0);
    // full negative trim, enable every third cycle: R4
    calSign = 1'b0;
    run(1, 15000, 1'b0);
    // small positive trim with pseudo-random enable and stop bursts: R9
    calMag = 5'd3; calSign = 1'b1;
    run(2, 8000, 1'b0);
    // calibration changing mid-minute: R7
    run(0, 4000, 1'b1);
    run(2, 4000, 1'b1);
    // magnitude zero: no second modified (R5), nominal length (R2)
    calMag = 5'd0; calSign = 1'b1;
    run(0, 4500, 1'b0);
    // R1 again: reset in the middle of a run clears phase
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 minutePhase after reset", int'(minutePhase), 0);
    check("R1 secTick after reset", int'(secTick), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule